// File: doc/BRIEF.md
# Serial Wiper Increment/Decrement Stepper

This block runs the fine-tuning mode of a serially controlled multi-channel digital potentiometer. The instruction decoder arms it once the increment/decrement instruction has been acknowledged, and passes it the index of the target pot. From then on, each high pulse on the serial clock moves that pot's wiper by exactly one segment. The serial data level, sampled when the clock rises, sets the direction: high steps toward the upper end and low steps toward the lower end. There is no byte framing and no acknowledge in this mode, so up-steps and down-steps can be mixed in any order.

The block holds the wiper registers for all pots. Each register holds a position from 0 up to the top of the array, and a step past either end has no effect. A stop or a start strobe from the bus front end leaves the mode, and control then returns to address reception. Stepping only touches the wiper registers. It never starts a nonvolatile write and never signals busy.

Top module: `wiper_stepper`

## Requirements
- R1: After reset every wiper register holds WIPER_RST (32 by default), `active` is 0, and `step_up` and `step_dn` are 0.
- R2: A one-cycle `arm` pulse sets `active` to 1 on the next clock and latches `pot_sel`. Pot p occupies bits [p*WBITS +: WBITS] of `wipers`.
- R3: While `active` is 1, a rising edge of `scl_i` with `sda_i` high adds 1 to the selected wiper. The new value and a one-cycle `step_up` pulse appear two clocks after the first clock that samples `scl_i` high.
- R4: While `active` is 1, a rising edge of `scl_i` with `sda_i` low subtracts 1 from the selected wiper, with a one-cycle `step_dn` pulse and the same timing as R3.
- R5: An up-step at 2**WBITS-1 (63) or a down-step at 0 leaves the wiper unchanged and produces no step pulse.
- R6: Only the latched pot changes. Changing `pot_sel` while `active` is 1 has no effect.
- R7: A `stop_stb` pulse clears `active`, and later clock pulses change no wiper.
- R8: A `start_stb` pulse clears `active` in the same way as R7.
- R9: While `active` is 0, clock pulses change no wiper and produce no step pulse.
- R10: A `start_stb` or `stop_stb` in the same cycle as a clock rise or as `arm` wins: no step is made and `active` ends at 0.
- R11: Only a rising edge of `scl_i` counts. A clock already high when `arm` arrives makes no step, and each pulse makes exactly one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized serial clock |
| sda_i | input | 1 | Synchronized serial data (step direction) |
| start_stb | input | 1 | Start condition strobe from bus front end |
| stop_stb | input | 1 | Stop condition strobe from bus front end |
| arm | input | 1 | Increment/decrement instruction acknowledged |
| pot_sel | input | SELW | Target pot index, latched on `arm` |
| wipers | output | NPOT*WBITS | All wiper registers, packed |
| step_up | output | 1 | One-cycle pulse: a wiper moved up |
| step_dn | output | 1 | One-cycle pulse: a wiper moved down |
| active | output | 1 | Stepping mode is active |

## Verification
Two functions can fall in the same cycle: a clock rise that would trigger a step, and a stop or start strobe that ends the mode. The bench provokes this by driving the clock high and raising `stop_stb` for the same single cycle, and separately by raising `start_stb` together with `arm`. In both cases it judges the result by an unchanged wiper, the absence of step pulses and `active` at 0. A sweep over every pot then walks each wiper from its current value down to 0 and up to 63, beyond both ends. After each pulse it compares the register with a value computed arithmetically and checks the count of step pulses.

// File: rtl/wiper_stepper_pkg.sv
package wiper_stepper_pkg;
  localparam int WS_NPOT_DEF  = 4;
  localparam int WS_WBITS_DEF = 6;

  typedef enum logic {
    WS_IDLE = 1'b0,
    WS_STEP = 1'b1
  } ws_mode_e;

  typedef struct packed {
    logic up;
    logic dn;
  } ws_req_t;
endpackage

// File: rtl/wstep_edge.sv
module wstep_edge (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  output logic scl_rise
);
  logic scl_q;

  always_ff @(posedge clk) begin
    if (rst) scl_q <= 1'b1;
    else     scl_q <= scl_i;
  end

  assign scl_rise = scl_i & ~scl_q;
endmodule

// File: rtl/wstep_mode.sv
module wstep_mode
  import wiper_stepper_pkg::*;
#(
  parameter int NPOT = WS_NPOT_DEF,
  localparam int SELW = (NPOT > 1) ? $clog2(NPOT) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scl_rise,
  input  logic            sda_i,
  input  logic            start_stb,
  input  logic            stop_stb,
  input  logic            arm,
  input  logic [SELW-1:0] pot_sel,
  output ws_req_t         req,
  output logic [SELW-1:0] sel_q,
  output logic            active
);
  ws_mode_e mode_q;
  logic     leave;

  assign leave  = start_stb | stop_stb;
  assign active = (mode_q == WS_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= WS_IDLE;
      sel_q  <= '0;
    end else if (leave) begin
      mode_q <= WS_IDLE;
    end else if (arm) begin
      mode_q <= WS_STEP;
      sel_q  <= pot_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req <= '0;
    end else begin
      req.up <= active & scl_rise & sda_i  & ~leave;
      req.dn <= active & scl_rise & ~sda_i & ~leave;
    end
  end
endmodule

// File: rtl/wstep_bank.sv
module wstep_bank
  import wiper_stepper_pkg::*;
#(
  parameter int NPOT      = WS_NPOT_DEF,
  parameter int WBITS     = WS_WBITS_DEF,
  parameter int WIPER_RST = 32,
  localparam int SELW = (NPOT > 1) ? $clog2(NPOT) : 1,
  localparam logic [WBITS-1:0] WMAX = {WBITS{1'b1}}
) (
  input  logic                   clk,
  input  logic                   rst,
  input  ws_req_t                req,
  input  logic [SELW-1:0]        sel_q,
  output logic [NPOT*WBITS-1:0]  wipers,
  output logic                   step_up,
  output logic                   step_dn
);
  logic [NPOT-1:0] mv_up;
  logic [NPOT-1:0] mv_dn;

  for (genvar p = 0; p < NPOT; p++) begin : g_pot
    logic [WBITS-1:0] pos_q;
    logic             hit;

    assign hit      = (sel_q == SELW'(p));
    assign mv_up[p] = hit & req.up & (pos_q != WMAX);
    assign mv_dn[p] = hit & req.dn & (pos_q != '0);

    always_ff @(posedge clk) begin
      if (rst)           pos_q <= WBITS'(WIPER_RST);
      else if (mv_up[p]) pos_q <= pos_q + 1'b1;
      else if (mv_dn[p]) pos_q <= pos_q - 1'b1;
    end

    assign wipers[p*WBITS +: WBITS] = pos_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_up <= 1'b0;
      step_dn <= 1'b0;
    end else begin
      step_up <= |mv_up;
      step_dn <= |mv_dn;
    end
  end
endmodule

// File: rtl/wiper_stepper.sv
module wiper_stepper
  import wiper_stepper_pkg::*;
#(
  parameter int NPOT      = WS_NPOT_DEF,
  parameter int WBITS     = WS_WBITS_DEF,
  parameter int WIPER_RST = 32,
  localparam int SELW = (NPOT > 1) ? $clog2(NPOT) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic                  start_stb,
  input  logic                  stop_stb,
  input  logic                  arm,
  input  logic [SELW-1:0]       pot_sel,
  output logic [NPOT*WBITS-1:0] wipers,
  output logic                  step_up,
  output logic                  step_dn,
  output logic                  active
);
  logic            scl_rise;
  ws_req_t         req;
  logic [SELW-1:0] sel_q;

  wstep_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .scl_rise (scl_rise)
  );

  wstep_mode #(.NPOT(NPOT)) u_mode (
    .clk       (clk),
    .rst       (rst),
    .scl_rise  (scl_rise),
    .sda_i     (sda_i),
    .start_stb (start_stb),
    .stop_stb  (stop_stb),
    .arm       (arm),
    .pot_sel   (pot_sel),
    .req       (req),
    .sel_q     (sel_q),
    .active    (active)
  );

  wstep_bank #(.NPOT(NPOT), .WBITS(WBITS), .WIPER_RST(WIPER_RST)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .sel_q   (sel_q),
    .wipers  (wipers),
    .step_up (step_up),
    .step_dn (step_dn)
  );
endmodule

// File: rtl/wiper_stepper_chk.sv
module wiper_stepper_chk #(
  parameter int NPOT  = 4,
  parameter int WBITS = 6,
  localparam int SELW = (NPOT > 1) ? $clog2(NPOT) : 1
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  scl_i,
  input logic                  sda_i,
  input logic                  start_stb,
  input logic                  stop_stb,
  input logic                  arm,
  input logic [SELW-1:0]       pot_sel,
  input logic [NPOT*WBITS-1:0] wipers,
  input logic                  step_up,
  input logic                  step_dn,
  input logic                  active
);
  AST_ONE_DIR: assert property (@(posedge clk) disable iff (rst)
    !(step_up && step_dn)); // R11

  AST_UP_CAUSE: assert property (@(posedge clk) disable iff (rst)
    step_up |-> ($past(active, 2) && $past(scl_i, 2) && $past(sda_i, 2))); // R3

  AST_DN_CAUSE: assert property (@(posedge clk) disable iff (rst)
    step_dn |-> ($past(active, 2) && $past(scl_i, 2) && !$past(sda_i, 2))); // R4

  AST_STEP_MOVES: assert property (@(posedge clk) disable iff (rst)
    (step_up || step_dn) |-> (wipers != $past(wipers))); // R5

  AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!step_up && !step_dn) |-> $stable(wipers)); // R9

  AST_STOP_EXIT: assert property (@(posedge clk) disable iff (rst)
    stop_stb |=> !active); // R7

  AST_START_EXIT: assert property (@(posedge clk) disable iff (rst)
    start_stb |=> !active); // R8

  AST_ARM_ENTER: assert property (@(posedge clk) disable iff (rst)
    (arm && !start_stb && !stop_stb) |=> active); // R2
endmodule

bind wiper_stepper wiper_stepper_chk #(.NPOT(NPOT), .WBITS(WBITS)) u_chk (.*);

// File: tb/wiper_stepper_bench.sv
module wiper_stepper_bench;
  localparam int NPOT = 4;
  localparam int WBITS = 6;
  localparam int RSTV = 32;
  localparam int MAXV = (1 << WBITS) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_i = 1'b1, sda_i = 1'b1, start_stb = 1'b0, stop_stb = 1'b0, arm = 1'b0;
  logic [1:0] pot_sel = '0;
  logic [NPOT*WBITS-1:0] wipers;
  logic step_up, step_dn, active;

  int tests = 0, fails = 0;
  int up_cnt = 0, dn_cnt = 0;
  int model [NPOT];
  bit done = 0;

  always #5 clk = ~clk;

  wiper_stepper u_wiper_stepper (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .start_stb(start_stb), .stop_stb(stop_stb), .arm(arm),
    .pot_sel(pot_sel), .wipers(wipers), .step_up(step_up),
    .step_dn(step_dn), .active(active)
  );

  always @(negedge clk) begin
    if (step_up) up_cnt++;
    if (step_dn) dn_cnt++;
  end

  function automatic int wip(int p);
    return int'(wipers[p*WBITS +: WBITS]);
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    for (int p = 0; p < NPOT; p++) check(req, wip(p), model[p]);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(bit d);
    sda_i = d;
    idle(2);
    scl_i = 1'b1;
    idle(4);
    scl_i = 1'b0;
    idle(2);
  endtask

  task automatic strobe_arm(int p);
    pot_sel = 2'(p);
    arm = 1'b1;
    idle(1);
    arm = 1'b0;
    idle(1);
  endtask

  task automatic strobe_stop();
    stop_stb = 1'b1;
    idle(1);
    stop_stb = 1'b0;
    idle(1);
  endtask

  task automatic step_model(int p, bit d);
    if (d && model[p] < MAXV) model[p]++;
    else if (!d && model[p] > 0) model[p]--;
  endtask

  initial begin
    int u0, d0, exp_up;
    for (int p = 0; p < NPOT; p++) model[p] = RSTV;
    idle(3);
    rst = 1'b0;
    scl_i = 1'b0;
    idle(2);
    // R1 reset state
    check_all("R1");
    check("R1 active", active, 0);
    check("R1 step", step_up | step_dn, 0);

    // R9 pulses while idle
    u0 = up_cnt; d0 = dn_cnt;
    pulse(1); pulse(0); pulse(1);
    check_all("R9");
    check("R9 pulses", up_cnt + dn_cnt - u0 - d0, 0);

    // R2 enter
    strobe_arm(1);
    check("R2 active", active, 1);
    // R3 up steps
    u0 = up_cnt;
    for (int i = 0; i < 5; i++) begin pulse(1); step_model(1, 1); end
    check("R3 value", wip(1), 37);
    check("R3 pulses", up_cnt - u0, 5);
    // R4 down steps
    d0 = dn_cnt;
    for (int i = 0; i < 3; i++) begin pulse(0); step_model(1, 0); end
    check("R4 value", wip(1), 34);
    check("R4 pulses", dn_cnt - d0, 3);
    // R6 pot_sel change ignored; mixed order
    pot_sel = 2'd3;
    pulse(1); step_model(1, 1);
    pulse(0); step_model(1, 0);
    pulse(1); step_model(1, 1);
    check_all("R6");

    // R5 saturation at top
    u0 = up_cnt;
    exp_up = MAXV - model[1];
    for (int i = 0; i < 40; i++) begin pulse(1); step_model(1, 1); end
    check("R5 top", wip(1), MAXV);
    check("R5 top pulses", up_cnt - u0, exp_up);

    // R7 stop ends mode
    strobe_stop();
    check("R7 active", active, 0);
    pulse(0); pulse(0);
    check_all("R7");

    // R8 start ends mode
    strobe_arm(2);
    pulse(0); step_model(2, 0);
    start_stb = 1'b1; idle(1); start_stb = 1'b0; idle(1);
    check("R8 active", active, 0);
    pulse(1);
    check_all("R8");

    // R10 stop in the same cycle as the clock rise
    strobe_arm(0);
    u0 = up_cnt;
    sda_i = 1'b1; idle(2);
    scl_i = 1'b1; stop_stb = 1'b1;
    idle(1);
    stop_stb = 1'b0;
    idle(3);
    scl_i = 1'b0; idle(2);
    check("R10 rise+stop", wip(0), model[0]);
    check("R10 pulses", up_cnt - u0, 0);
    check("R10 active", active, 0);
    // R10 start with arm
    start_stb = 1'b1; pot_sel = 2'd0; arm = 1'b1;
    idle(1);
    start_stb = 1'b0; arm = 1'b0;
    idle(1);
    check("R10 arm+start", active, 0);

    // R11 clock already high at arm
    sda_i = 1'b1; idle(1);
    scl_i = 1'b1; idle(2);
    strobe_arm(3);
    idle(2);
    scl_i = 1'b0; idle(2);
    check("R11 level", wip(3), model[3]);
    pulse(1); step_model(3, 1);
    check("R11 one step", wip(3), model[3]);
    strobe_stop();

    // Sweep: every pot down past 0 then up past the top
    for (int p = 0; p < NPOT; p++) begin
      strobe_arm(p);
      for (int i = 0; i < 66; i++) begin
        u0 = dn_cnt;
        exp_up = (model[p] > 0) ? 1 : 0;
        pulse(0); step_model(p, 0);
        check("R4/R5 sweep dn", wip(p), model[p]);
        check("R5 sweep dn pulse", dn_cnt - u0, exp_up);
      end
      for (int i = 0; i < 66; i++) begin
        u0 = up_cnt;
        exp_up = (model[p] < MAXV) ? 1 : 0;
        pulse(1); step_model(p, 1);
        check("R3/R5 sweep up", wip(p), model[p]);
        check("R5 sweep up pulse", up_cnt - u0, exp_up);
      end
      strobe_stop();
      check_all("R6 sweep");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule